// File: doc/BRIEF.md
# Trace ID Acceptance Filter

This block sits in front of two trace-buffer sinks and decides, beat by beat, which trace data each sink stores. Every sink port has its own 128-bit acceptance mask with one bit per 7-bit trace ID. A beat whose ID bit is set in that port's mask passes to the sink under normal valid/ready flow control. A beat whose ID bit is clear is taken at once and discarded. All mask bits are zero after reset, so no trace data reaches either sink until software enables an ID.

Software reaches the masks over a simple memory-mapped register port that reads in the same cycle. Each mask is four 32-bit words. Trace ID n lives in word n / 32 at bit n % 32 of the port's mask. Software enables or disables one source by reading the word, changing the one bit and writing the word back. Writes to the mask words are refused until a key is written to a lock-access register. Any other value written there locks the unit again.

Top module: `trace_id_filter_unit`

## Requirements
- R1: After reset every mask word reads 0x00000000 and the unit is locked. A read at 0xFB4 returns 0x00000002, where bit 1 set means locked. Every beat is discarded until an ID is enabled.
- R2: Writing 0xC5ACCE55 to offset 0xFB0 unlocks the unit, and a read at 0xFB4 then returns 0. Writing any other value to 0xFB0 locks it, and the read returns 0x00000002. A read at 0xFB0 returns 0.
- R3: While the unit is locked, writes to mask words change nothing. Reads still return the current mask contents.
- R4: The word for ID n on port p is at BASE_p + 4*(n/32) and holds the ID at bit n%32. BASE_0 is 0x0F8 and BASE_1 is 0x108. Each port spans 0x10 bytes.
- R5: A beat whose ID bit is set in its port's mask asserts out_valid with the same data and ID. It sees in_ready equal to out_ready, so it waits while the sink stalls.
- R6: A beat whose ID bit is clear sees in_ready high and out_valid low in the same cycle, and nothing is forwarded.
- R7: A mask write takes effect from the cycle after the write edge. A beat that is already presented but not yet accepted is judged by the updated mask.
- R8: Reads at offsets outside the defined registers return 0, and misaligned offsets count as outside. Writes to those offsets leave every mask unchanged.
- R9: The two ports filter independently. An ID enabled on one port does not pass beats on the other port.
- R10: reg_rdata is 0 whenever reg_rd is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_rd | input | 1 | Register read strobe; data returned in the same cycle |
| reg_addr | input | 12 | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data |
| in_valid | input | NUM_PORTS | Per-port incoming beat valid |
| in_ready | output | NUM_PORTS | Per-port incoming beat accepted |
| in_data | input | NUM_PORTS*32 | Per-port beat payload, port p in bits [p*32 +: 32] |
| in_id | input | NUM_PORTS*7 | Per-port trace ID, port p in bits [p*7 +: 7] |
| out_valid | output | NUM_PORTS | Per-port beat offered to the sink |
| out_ready | input | NUM_PORTS | Per-port sink ready |
| out_data | output | NUM_PORTS*32 | Per-port forwarded payload |
| out_id | output | NUM_PORTS*7 | Per-port forwarded trace ID |

## Verification
The properties assume that reg_wr and reg_rd are never asserted in the same cycle, and that a write strobe lasts exactly one clock. They also assume that in_data and in_id carry known values whenever in_valid is high. The stimulus drives every input only on the falling edge. It issues register accesses one at a time through tasks that pulse a single strobe, and it parks the beat inputs at defined values whenever no beat is presented. The stall and mid-stall mask-change cases hold a beat steady across several edges, which keeps the forwarding properties inside the valid/ready contract they were written for.

// File: rtl/tidf_pkg.sv
// Package: shared constants of the trace ID acceptance filter.
// Assumes trace IDs are 7 bits and register words are 32 bits.
package tidf_pkg;
    localparam int ADDR_W     = 12;
    localparam int WORD_W     = 32;
    localparam int ID_W       = 7;
    localparam int ID_SPACE   = 1 << ID_W;
    localparam int MASK_WORDS = ID_SPACE / WORD_W;
    localparam logic [WORD_W-1:0] UNLOCK_KEY       = 32'hC5AC_CE55;
    localparam logic [ADDR_W-1:0] LOCK_ACCESS_ADDR = 12'hFB0;
    localparam logic [ADDR_W-1:0] LOCK_STATUS_ADDR = 12'hFB4;
    localparam int LOCK_STATUS_BIT = 1;
endpackage

// File: rtl/tidf_lock_gate.sv
// Module: lock gate for the configuration registers.
// Holds the lock state. A write of the key to the access register
// unlocks and any other value relocks. The status register reports the state.
// Assumes single-cycle write strobes; reset leaves the unit locked.
module tidf_lock_gate
    import tidf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic              locked,
    output logic              mask_wr_ok,
    output logic [WORD_W-1:0] status_word
);

    logic access_hit;
    logic status_hit;

    // Decode of the two lock registers.
    always_comb begin
        access_hit = (reg_addr == LOCK_ACCESS_ADDR);
        status_hit = (reg_addr == LOCK_STATUS_ADDR);
    end

    // Lock state: key unlocks, any other value written relocks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked <= 1'b1;
        end else if (reg_wr && access_hit) begin
            locked <= (reg_wdata != UNLOCK_KEY);
        end
    end

    // Write permission for the mask words and status read word.
    always_comb begin
        mask_wr_ok  = ~locked;
        status_word = '0;
        if (status_hit) begin
            status_word[LOCK_STATUS_BIT] = locked;
        end
    end

endmodule

// File: rtl/tidf_mask_bank.sv
// Module: acceptance mask of one sink port.
// Stores MASK_WORDS word registers starting at byte offset BASE. Together
// they form one bit per trace ID. Only aligned offsets inside the window
// hit. Assumes MASK_WORDS is a power of two of at least 2.
module tidf_mask_bank
    import tidf_pkg::*;
#(
    parameter logic [ADDR_W-1:0] BASE = 12'h0F8
)(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [WORD_W-1:0]   reg_wdata,
    output logic [ID_SPACE-1:0] mask,
    output logic [WORD_W-1:0]   rd_word
);

    localparam int SEL_W = $clog2(MASK_WORDS);

    logic [ADDR_W-1:0] offs;
    logic              hit;
    logic [SEL_W-1:0]  sel;
    logic [WORD_W-1:0] words [MASK_WORDS];

    // Window decode: offset relative to base, aligned and in range.
    always_comb begin
        offs = reg_addr - BASE;
        hit  = (offs[ADDR_W-1:SEL_W+2] == '0) && (offs[1:0] == 2'b00);
        sel  = offs[SEL_W+1:2];
    end

    for (genvar w = 0; w < MASK_WORDS; w++) begin : g_word
        // One mask word: cleared on reset, loaded by a permitted write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                words[w] <= '0;
            end else if (wr_en && hit && (sel == SEL_W'(w))) begin
                words[w] <= reg_wdata;
            end
        end
        assign mask[w*WORD_W +: WORD_W] = words[w];
    end

    // Read word of this port, zero when the window is not hit.
    always_comb begin
        rd_word = hit ? words[sel] : '0;
    end

endmodule

// File: rtl/tidf_beat_filter.sv
// Module: valid/ready filter for one sink port.
// A beat whose ID bit is set flows through under the sink's ready. Any
// other beat is accepted at once and dropped. The filter is combinational,
// so a mask change applies to a beat still waiting.
module tidf_beat_filter
    import tidf_pkg::*;
#(
    parameter int BEAT_W = 32
)(
    input  logic [ID_SPACE-1:0] mask,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [BEAT_W-1:0]   in_data,
    input  logic [ID_W-1:0]     in_id,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [BEAT_W-1:0]   out_data,
    output logic [ID_W-1:0]     out_id
);

    logic accept_id;

    // Pass/drop decision and handshake steering.
    always_comb begin
        accept_id = mask[in_id];
        out_valid = in_valid & accept_id;
        in_ready  = ~accept_id | out_ready;
        out_data  = in_data;
        out_id    = in_id;
    end

endmodule

// File: rtl/trace_id_filter_unit.sv
// Module: trace ID acceptance filter, top level.
// Holds one lock gate, plus a mask bank and a beat filter for each sink
// port. Register reads complete in the same cycle. Assumes reg_wr and
// reg_rd are never high together and the port windows do not overlap.
module trace_id_filter_unit
    import tidf_pkg::*;
#(
    parameter int NUM_PORTS = 2,
    parameter int BEAT_W    = 32,
    parameter logic [NUM_PORTS*ADDR_W-1:0] PORT_BASES = {12'h108, 12'h0F8}
)(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      reg_wr,
    input  logic                      reg_rd,
    input  logic [ADDR_W-1:0]         reg_addr,
    input  logic [WORD_W-1:0]         reg_wdata,
    output logic [WORD_W-1:0]         reg_rdata,
    input  logic [NUM_PORTS-1:0]      in_valid,
    output logic [NUM_PORTS-1:0]      in_ready,
    input  logic [NUM_PORTS*BEAT_W-1:0] in_data,
    input  logic [NUM_PORTS*ID_W-1:0] in_id,
    output logic [NUM_PORTS-1:0]      out_valid,
    input  logic [NUM_PORTS-1:0]      out_ready,
    output logic [NUM_PORTS*BEAT_W-1:0] out_data,
    output logic [NUM_PORTS*ID_W-1:0] out_id
);

    logic                          locked;
    logic                          mask_wr_ok;
    logic [WORD_W-1:0]             status_word;
    logic [NUM_PORTS*ID_SPACE-1:0] mask_flat;
    logic [WORD_W-1:0]             port_rd [NUM_PORTS];

    tidf_lock_gate u_lock (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr      (reg_wr),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .locked      (locked),
        .mask_wr_ok  (mask_wr_ok),
        .status_word (status_word)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        tidf_mask_bank #(
            .BASE (PORT_BASES[p*ADDR_W +: ADDR_W])
        ) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (reg_wr & mask_wr_ok),
            .reg_addr  (reg_addr),
            .reg_wdata (reg_wdata),
            .mask      (mask_flat[p*ID_SPACE +: ID_SPACE]),
            .rd_word   (port_rd[p])
        );

        tidf_beat_filter #(
            .BEAT_W (BEAT_W)
        ) u_filter (
            .mask      (mask_flat[p*ID_SPACE +: ID_SPACE]),
            .in_valid  (in_valid[p]),
            .in_ready  (in_ready[p]),
            .in_data   (in_data[p*BEAT_W +: BEAT_W]),
            .in_id     (in_id[p*ID_W +: ID_W]),
            .out_valid (out_valid[p]),
            .out_ready (out_ready[p]),
            .out_data  (out_data[p*BEAT_W +: BEAT_W]),
            .out_id    (out_id[p*ID_W +: ID_W])
        );
    end

    // Read mux: OR of all register sources, zero without a read strobe.
    always_comb begin
        logic [WORD_W-1:0] acc;
        acc = status_word;
        for (int p = 0; p < NUM_PORTS; p++) begin
            acc = acc | port_rd[p];
        end
        reg_rdata = reg_rd ? acc : '0;
    end

endmodule

// File: rtl/tidf_checker.sv
// Module: property checker for the trace ID acceptance filter, bound to
// the top level. Assumes the default port map for the unmapped-range check.
module tidf_checker
    import tidf_pkg::*;
#(
    parameter int NUM_PORTS = 2,
    parameter int BEAT_W    = 32,
    parameter logic [ADDR_W-1:0] MAP_LO = 12'h0F8,
    parameter logic [ADDR_W-1:0] MAP_HI = 12'h118
)(
    input logic                          clk,
    input logic                          rst_n,
    input logic                          reg_wr,
    input logic                          reg_rd,
    input logic [ADDR_W-1:0]             reg_addr,
    input logic [WORD_W-1:0]             reg_wdata,
    input logic [WORD_W-1:0]             reg_rdata,
    input logic [NUM_PORTS-1:0]          in_valid,
    input logic [NUM_PORTS-1:0]          in_ready,
    input logic [NUM_PORTS*BEAT_W-1:0]   in_data,
    input logic [NUM_PORTS*ID_W-1:0]     in_id,
    input logic [NUM_PORTS-1:0]          out_valid,
    input logic [NUM_PORTS-1:0]          out_ready,
    input logic [NUM_PORTS*BEAT_W-1:0]   out_data,
    input logic [NUM_PORTS*ID_W-1:0]     out_id,
    input logic                          locked,
    input logic [NUM_PORTS*ID_SPACE-1:0] mask_flat
);

    assert_unlock_R2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && reg_addr == LOCK_ACCESS_ADDR && reg_wdata == UNLOCK_KEY |=> !locked);

    assert_relock_R2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && reg_addr == LOCK_ACCESS_ADDR && reg_wdata != UNLOCK_KEY |=> locked);

    assert_locked_ignore_R3: assert property (@(posedge clk) disable iff (!rst_n)
        locked && reg_wr && reg_addr != LOCK_ACCESS_ADDR |=> $stable(mask_flat));

    assert_unmapped_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd && (reg_addr < MAP_LO || (reg_addr >= MAP_HI && reg_addr < LOCK_ACCESS_ADDR)
                   || reg_addr > LOCK_STATUS_ADDR || reg_addr[1:0] != 2'b00) |-> reg_rdata == '0);

    assert_unmapped_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && (reg_addr < MAP_LO || (reg_addr >= MAP_HI && reg_addr < LOCK_ACCESS_ADDR))
        |=> $stable(mask_flat));

    assert_idle_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |-> reg_rdata == '0);

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
        assert_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid[p] && !mask_flat[p*ID_SPACE + int'(in_id[p*ID_W +: ID_W])]
            |-> in_ready[p] && !out_valid[p]);

        assert_forward_R5: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[p] |-> in_valid[p]
                && out_data[p*BEAT_W +: BEAT_W] == in_data[p*BEAT_W +: BEAT_W]
                && out_id[p*ID_W +: ID_W] == in_id[p*ID_W +: ID_W]);

        assert_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[p] && !out_ready[p] |-> !in_ready[p]);
    end

endmodule

bind trace_id_filter_unit tidf_checker #(
    .NUM_PORTS (NUM_PORTS),
    .BEAT_W    (BEAT_W)
) u_tidf_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .in_id     (in_id),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_id    (out_id),
    .locked    (locked),
    .mask_flat (mask_flat)
);

// File: tb/trace_id_filter_unit_test.sv
module trace_id_filter_unit_test;

    localparam int NP = 2;
    localparam int BW = 32;
    localparam int IW = 7;

    // Vector: {port, id[6:0], expect_pass}
    localparam int NVEC = 12;
    localparam logic [8:0] VEC [NVEC] = '{
        {1'b0, 7'd0,   1'b1}, {1'b0, 7'd5,   1'b1}, {1'b0, 7'd31,  1'b1},
        {1'b0, 7'd32,  1'b1}, {1'b0, 7'd127, 1'b1}, {1'b0, 7'd64,  1'b0},
        {1'b0, 7'd6,   1'b0}, {1'b1, 7'd64,  1'b1}, {1'b1, 7'd100, 1'b1},
        {1'b1, 7'd5,   1'b0}, {1'b1, 7'd127, 1'b0}, {1'b1, 7'd0,   1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr = 1'b0, reg_rd = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [NP-1:0] in_valid = '0, in_ready, out_valid, out_ready = '1;
    logic [NP*BW-1:0] in_data = '0, out_data;
    logic [NP*IW-1:0] in_id = '0, out_id;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    trace_id_filter_unit uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_id(in_id),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_id(out_id)
    );

    task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        reg_rd = 1'b0;
    endtask

    function automatic logic [11:0] word_addr(input int port, input int id);
        return (port == 0 ? 12'h0F8 : 12'h108) + 12'((id / 32) * 4);
    endfunction

    // Read-modify-write of one ID bit (R4 layout).
    task automatic set_id(input int port, input int id, input bit en);
        logic [31:0] w;
        reg_read(word_addr(port, id), w);
        if (en) w[id % 32] = 1'b1; else w[id % 32] = 1'b0;
        reg_write(word_addr(port, id), w);
    endtask

    task automatic present(input int port, input int id, input logic [31:0] d, input logic rdy);
        @(negedge clk);
        in_valid = '0; out_ready = '1;
        in_valid[port] = 1'b1;
        in_id[port*IW +: IW] = IW'(id);
        in_data[port*BW +: BW] = d;
        out_ready[port] = rdy;
        #1;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int a = 'h0F8; a < 'h118; a += 4) begin
            reg_read(12'(a), r);
            check_eq("R1 mask word zero", r, 32'h0);
        end
        reg_read(12'hFB4, r);
        check_eq("R1 locked status", r, 32'h2);
        present(0, 5, 32'h1111_0000, 1'b1);
        check_eq("R1 beat dropped out_valid", {31'b0, out_valid[0]}, 32'h0);
        check_eq("R1 beat dropped in_ready", {31'b0, in_ready[0]}, 32'h1);
        @(negedge clk); in_valid = '0;

        // R3: write while locked ignored
        reg_write(12'h0F8, 32'hFFFF_FFFF);
        reg_read(12'h0F8, r);
        check_eq("R3 locked write ignored", r, 32'h0);

        // R2: unlock
        reg_write(12'hFB0, 32'hC5AC_CE55);
        reg_read(12'hFB4, r);
        check_eq("R2 unlocked status", r, 32'h0);
        reg_read(12'hFB0, r);
        check_eq("R2 access reg reads zero", r, 32'h0);

        // R4: build masks by read-modify-write
        set_id(0, 0, 1); set_id(0, 5, 1); set_id(0, 31, 1);
        set_id(0, 32, 1); set_id(0, 127, 1);
        set_id(1, 64, 1); set_id(1, 100, 1);
        reg_read(12'h0F8, r); check_eq("R4 port0 word0", r, 32'h8000_0021);
        reg_read(12'h0FC, r); check_eq("R4 port0 word1", r, 32'h0000_0001);
        reg_read(12'h104, r); check_eq("R4 port0 word3", r, 32'h8000_0000);
        reg_read(12'h110, r); check_eq("R4 port1 word2", r, 32'h0000_0001);
        reg_read(12'h114, r); check_eq("R4 port1 word3", r, 32'h0000_0010);
        reg_read(12'h108, r); check_eq("R4 port1 word0", r, 32'h0);

        // R5 R6 R9: vector table
        for (int v = 0; v < NVEC; v++) begin
            int p, id;
            logic exp_pass;
            logic [31:0] d;
            p = int'(VEC[v][8]);
            id = int'(VEC[v][7:1]);
            exp_pass = VEC[v][0];
            d = 32'hA500_0000 + 32'(v);
            present(p, id, d, 1'b1);
            check_eq("R5/R6/R9 out_valid", {31'b0, out_valid[p]}, {31'b0, exp_pass});
            check_eq("R5/R6 in_ready", {31'b0, in_ready[p]}, 32'h1);
            check_eq("R9 other port idle", {31'b0, out_valid[1-p]}, 32'h0);
            if (exp_pass) begin
                check_eq("R5 data forwarded", out_data[p*BW +: BW], d);
                check_eq("R5 id forwarded", {25'b0, out_id[p*IW +: IW]}, 32'(id));
            end
        end
        @(negedge clk); in_valid = '0;

        // R5: stall
        present(0, 5, 32'hBEEF_0005, 1'b0);
        check_eq("R5 stalled out_valid", {31'b0, out_valid[0]}, 32'h1);
        check_eq("R5 stalled in_ready", {31'b0, in_ready[0]}, 32'h0);
        out_ready[0] = 1'b1; #1;
        check_eq("R5 released in_ready", {31'b0, in_ready[0]}, 32'h1);

        // R7: pending beat judged by new mask
        out_ready[0] = 1'b0; #1;
        check_eq("R7 pending before write", {31'b0, out_valid[0]}, 32'h1);
        reg_write(12'h0F8, 32'h8000_0001);
        #1;
        check_eq("R7 pending now dropped out_valid", {31'b0, out_valid[0]}, 32'h0);
        check_eq("R7 pending now dropped in_ready", {31'b0, in_ready[0]}, 32'h1);
        @(negedge clk); in_valid = '0; out_ready = '1;

        // R8: unmapped offsets
        reg_write(12'h118, 32'hFFFF_FFFF);
        reg_write(12'h0F4, 32'hFFFF_FFFF);
        reg_write(12'h0FA, 32'hFFFF_FFFF);
        reg_read(12'h118, r); check_eq("R8 read 0x118", r, 32'h0);
        reg_read(12'h0F4, r); check_eq("R8 read 0x0F4", r, 32'h0);
        reg_read(12'h0FA, r); check_eq("R8 misaligned read", r, 32'h0);
        reg_read(12'h108, r); check_eq("R8 mask untouched p1", r, 32'h0);
        reg_read(12'h0F8, r); check_eq("R8 mask untouched p0", r, 32'h8000_0001);

        // R10: no read strobe
        @(negedge clk); reg_addr = 12'h0F8; #1;
        check_eq("R10 idle rdata", reg_rdata, 32'h0);

        // R2/R3: relock, reads still work
        reg_write(12'hFB0, 32'h0000_0000);
        reg_read(12'hFB4, r); check_eq("R2 relocked status", r, 32'h2);
        reg_write(12'h0F8, 32'h0);
        reg_read(12'h0F8, r); check_eq("R3 read while locked", r, 32'h8000_0001);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule